// File: doc/BRIEF.md
# Data Effective Address Unit

This unit turns the operand fields of a data-access instruction into a 24-bit effective address for a byte-oriented controller whose memory is split into 64K regions. Decode supplies a 3-bit mode code together with the raw operand material: a direct address field, the contents of a 16-bit word register and a 32-bit double-word register, a 16-bit displacement and a 2-bit short-immediate code.

The unit applies the mapping for the chosen mode. This covers zero extension into region 00, sign extension of the displacement, and wrap-around either inside region 00 or across the full 24-bit space. It also flags accesses that go to the special-function register space instead of data memory. A fault is raised when the register contents are illegal. For the increment and decrement forms, the unit decodes the short immediate.

The arithmetic is combinational. A single register stage follows it, and a valid bit travels alongside the data with a latency of one cycle.

Top module: `ea_gen`

## Requirements
- R1: Mode 0 (8-bit direct) with field bit 7 clear gives ea = 00:00xx, where xx is field bits 7..0, and sfr_sel = 0.
- R2: Mode 0 with field bit 7 set gives sfr_sel = 1 and ea = 00:00xx, where xx is field bits 7..0 (SFR address 0x80..0xFF).
- R3: Mode 1 (16-bit direct) gives ea = {8'h00, field[15:0]}, with sfr_sel = 0 and fault = 0.
- R4: Mode 2 (word-register indirect) gives ea = {8'h00, wreg}.
- R5: Mode 3 (double-word-register indirect) gives ea = dreg[23:0]. fault = 1 exactly when dreg[31:24] is non-zero.
- R6: Mode 4 (word register plus displacement) gives ea = {8'h00, (wreg + disp) mod 2^16}, so the sum wraps inside region 00.
- R7: Mode 5 (double-word register plus signed displacement) gives ea = (dreg[23:0] + sign-extended disp) mod 2^24. fault = 1 exactly when dreg[31:24] is non-zero.
- R8: Mode 6 (short immediate) gives ea = 0. short_val is 1, 2 or 4 for code 2'b00, 2'b01 or 2'b10. Code 2'b11 gives short_val = 0 and fault = 1.
- R9: Mode 7 (register-file alias) gives ea = field[4:0] zero-extended, which lies in 00:0000..00:001F. Field bits 15..5 are ignored.
- R10: out_valid equals in_valid from the previous cycle. While in_valid is low, ea, sfr_sel, fault and short_val hold their values.
- R11: After synchronous reset, out_valid, ea, sfr_sel, fault and short_val are all 0.
- R12: fault is raised only in modes 3, 5 and 6. sfr_sel is raised only in mode 0. In all other modes short_val = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand fields are valid this cycle |
| mode | input | 3 | Addressing mode code (0..7) |
| dir_addr | input | 16 | Direct address or register index field |
| wreg | input | 16 | Word register contents |
| dreg | input | 32 | Double-word register contents |
| disp | input | 16 | Displacement, signed in mode 5 |
| short_code | input | 2 | Short-immediate code |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| ea | output | 24 | Effective address |
| sfr_sel | output | 1 | Access goes to SFR space |
| fault | output | 1 | Illegal register contents or immediate code |
| short_val | output | 3 | Decoded short immediate |

## Verification
The bench sweeps all 256 eight-bit direct values across the 0x7F/0x80 boundary. A design that split the range at the wrong bit would either send low RAM to the SFR space or let SFRs fall through into memory.

Word-plus-displacement sums are driven past 0xFFFF, and double-word sums with negative displacements are driven below zero. Carry that leaks into the upper byte, or a zero-extended displacement, would show up as a wrong region or a large positive jump. Double-word values with non-zero top bytes are used to confirm that the fault fires while the address stays truncated. All four short codes are applied, and register-alias fields are given junk in their upper bits.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    M_DIR8   = 3'd0,
    M_DIR16  = 3'd1,
    M_IND_W  = 3'd2,
    M_IND_D  = 3'd3,
    M_DISP_W = 3'd4,
    M_DISP_D = 3'd5,
    M_SHORT  = 3'd6,
    M_REG    = 3'd7
  } ea_mode_e;
endpackage

// File: rtl/ea_direct.sv
module ea_direct
  import ea_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DIR_W  = 16,
  parameter int DIR8_W = 8,
  parameter int RF_W   = 5
) (
  input  ea_mode_e            mode,
  input  logic [DIR_W-1:0]    dir,
  output logic [ADDR_W-1:0]   addr,
  output logic                sfr
);
  // Direct and register-alias mapping; all land in region 00
  always_comb begin
    addr = '0;
    sfr  = 1'b0;
    case (mode)
      M_DIR8: begin
        addr[DIR8_W-1:0] = dir[DIR8_W-1:0];
        sfr              = dir[DIR8_W-1];
      end
      M_DIR16: addr[DIR_W-1:0] = dir;
      M_REG:   addr[RF_W-1:0]  = dir[RF_W-1:0];
      default: ;
    endcase
  end
endmodule

// File: rtl/ea_regcalc.sv
module ea_regcalc
  import ea_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WREG_W = 16,
  parameter int DREG_W = 32,
  parameter int DISP_W = 16
) (
  input  ea_mode_e            mode,
  input  logic [WREG_W-1:0]   wreg,
  input  logic [DREG_W-1:0]   dreg,
  input  logic [DISP_W-1:0]   disp,
  output logic [ADDR_W-1:0]   addr,
  output logic                fault
);
  localparam int PAGE_W = ADDR_W - WREG_W;
  localparam int EXT_W  = ADDR_W - DISP_W;

  logic [WREG_W-1:0] wsum;
  logic [ADDR_W-1:0] dsum;
  logic [ADDR_W-1:0] disp_sx;
  logic              upper_nz;

  assign wsum     = wreg + disp;  // wraps inside the region
  assign disp_sx  = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign dsum     = dreg[ADDR_W-1:0] + disp_sx;
  assign upper_nz = |dreg[DREG_W-1:ADDR_W];

  always_comb begin
    addr  = '0;
    fault = 1'b0;
    case (mode)
      M_IND_W:  addr = {{PAGE_W{1'b0}}, wreg};
      M_IND_D: begin
        addr  = dreg[ADDR_W-1:0];
        fault = upper_nz;
      end
      M_DISP_W: addr = {{PAGE_W{1'b0}}, wsum};
      M_DISP_D: begin
        addr  = dsum;
        fault = upper_nz;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ea_shortimm.sv
module ea_shortimm #(
  parameter int IMM_W = 3
) (
  input  logic [1:0]       code,
  output logic [IMM_W-1:0] val,
  output logic             bad
);
  always_comb begin
    val = '0;
    bad = 1'b0;
    if (code == 2'b11) bad = 1'b1;
    else               val = IMM_W'(1) << code;
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DIR_W  = 16,
  parameter int WREG_W = 16,
  parameter int DREG_W = 32,
  parameter int DISP_W = 16,
  parameter int IMM_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        mode,
  input  logic [DIR_W-1:0]  dir_addr,
  input  logic [WREG_W-1:0] wreg,
  input  logic [DREG_W-1:0] dreg,
  input  logic [DISP_W-1:0] disp,
  input  logic [1:0]        short_code,
  output logic              out_valid,
  output logic [ADDR_W-1:0] ea,
  output logic              sfr_sel,
  output logic              fault,
  output logic [IMM_W-1:0]  short_val
);
  ea_mode_e m;
  assign m = ea_mode_e'(mode);

  logic [ADDR_W-1:0] dir_ea, reg_ea, nxt_ea;
  logic              dir_sfr, reg_fault, imm_bad, nxt_fault;
  logic [IMM_W-1:0]  imm_val, nxt_imm;

  ea_direct #(.ADDR_W(ADDR_W), .DIR_W(DIR_W)) u_dir (
    .mode(m), .dir(dir_addr), .addr(dir_ea), .sfr(dir_sfr)
  );

  ea_regcalc #(.ADDR_W(ADDR_W), .WREG_W(WREG_W), .DREG_W(DREG_W),
               .DISP_W(DISP_W)) u_reg (
    .mode(m), .wreg(wreg), .dreg(dreg), .disp(disp),
    .addr(reg_ea), .fault(reg_fault)
  );

  ea_shortimm #(.IMM_W(IMM_W)) u_imm (
    .code(short_code), .val(imm_val), .bad(imm_bad)
  );

  always_comb begin
    nxt_ea    = dir_ea | reg_ea;  // each unit drives zero outside its modes
    nxt_fault = reg_fault;
    nxt_imm   = '0;
    if (m == M_SHORT) begin
      nxt_fault = imm_bad;
      nxt_imm   = imm_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      ea        <= '0;
      sfr_sel   <= 1'b0;
      fault     <= 1'b0;
      short_val <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ea        <= nxt_ea;
        sfr_sel   <= dir_sfr;
        fault     <= nxt_fault;
        short_val <= nxt_imm;
      end
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int ADDR_W = 24,
  parameter int DIR_W  = 16,
  parameter int IMM_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        mode,
  input logic [DIR_W-1:0]  dir_addr,
  input logic [1:0]        short_code,
  input logic              out_valid,
  input logic [ADDR_W-1:0] ea,
  input logic              sfr_sel,
  input logic              fault,
  input logic [IMM_W-1:0]  short_val
);
  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_drops_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(ea) && $stable(fault) && $stable(sfr_sel));
  assert_sfr_split_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd0) |=> sfr_sel == $past(dir_addr[7]));
  assert_dir16_region0_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd1) |=> ea[ADDR_W-1:16] == '0 && !fault && !sfr_sel);
  assert_word_region0_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (mode == 3'd2 || mode == 3'd4)) |=> ea[ADDR_W-1:16] == '0 && !fault);
  assert_short_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd6 && short_code != 2'b11) |=> $countones(short_val) == 1 && !fault);
  assert_regalias_range_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd7) |=> ea < 32 && !fault && !sfr_sel);
endmodule

bind ea_gen ea_gen_chk #(.ADDR_W(ADDR_W), .DIR_W(DIR_W), .IMM_W(IMM_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .dir_addr(dir_addr),
  .short_code(short_code), .out_valid(out_valid), .ea(ea), .sfr_sel(sfr_sel),
  .fault(fault), .short_val(short_val)
);

// File: tb/tb_ea_gen.sv
module tb_ea_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  mode = '0;
  logic [15:0] dir_addr = '0;
  logic [15:0] wreg = '0;
  logic [31:0] dreg = '0;
  logic [15:0] disp = '0;
  logic [1:0]  short_code = '0;
  logic        out_valid;
  logic [23:0] ea;
  logic        sfr_sel, fault;
  logic [2:0]  short_val;

  int vectors = 0;
  int fails = 0;

  always #2 clk = ~clk;  // 250 MHz

  ea_gen dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .dir_addr(dir_addr),
    .wreg(wreg), .dreg(dreg), .disp(disp), .short_code(short_code),
    .out_valid(out_valid), .ea(ea), .sfr_sel(sfr_sel), .fault(fault),
    .short_val(short_val)
  );

  function automatic string req_of(input logic [2:0] md, input logic [15:0] d);
    case (md)
      3'd0: return d[7] ? "R2" : "R1";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Reference model built from the requirement text
  task automatic model(input logic [2:0] md, input logic [15:0] d, input logic [15:0] w,
                       input logic [31:0] dw, input logic [15:0] ds, input logic [1:0] sc,
                       output logic [23:0] e, output logic s, output logic f,
                       output logic [2:0] iv);
    int signed sd;
    sd = $signed(ds);
    e = 0; s = 0; f = 0; iv = 0;
    case (md)
      3'd0: begin e = {16'h0, d[7:0]}; s = (d[7:0] >= 8'h80); end
      3'd1: e = {8'h00, d};
      3'd2: e = {8'h00, w};
      3'd3: begin e = dw[23:0]; f = (dw >= 32'h0100_0000); end
      3'd4: e = 24'((int'(w) + int'(ds)) % 65536);
      3'd5: begin e = 24'(int'(dw[23:0]) + sd); f = (dw >= 32'h0100_0000); end
      3'd6: begin
        if (sc == 2'd3) f = 1;
        else iv = (sc == 2'd0) ? 3'd1 : (sc == 2'd1) ? 3'd2 : 3'd4;
      end
      default: e = 24'(d % 32);
    endcase
  endtask

  task automatic apply(input logic [2:0] md, input logic [15:0] d, input logic [15:0] w,
                       input logic [31:0] dw, input logic [15:0] ds, input logic [1:0] sc);
    logic [23:0] e; logic s, f; logic [2:0] iv;
    model(md, d, w, dw, ds, sc, e, s, f, iv);
    @(negedge clk);
    mode = md; dir_addr = d; wreg = w; dreg = dw; disp = ds; short_code = sc;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    vectors++;
    if (out_valid !== 1'b1 || ea !== e || sfr_sel !== s || fault !== f || short_val !== iv) begin
      fails++;
      $display("FAIL %s/R12 mode=%0d: got v=%b ea=%h sfr=%b flt=%b imm=%0d, expected v=1 ea=%h sfr=%b flt=%b imm=%0d",
               req_of(md, d), md, out_valid, ea, sfr_sel, fault, short_val, e, s, f, iv);
    end
  endtask

  // R10: inputs changed while in_valid low must not move outputs
  task automatic idle_check();
    logic [23:0] e0; logic s0, f0; logic [2:0] i0;
    e0 = ea; s0 = sfr_sel; f0 = fault; i0 = short_val;
    mode = 3'd3; dreg = 32'hFF12_3456; dir_addr = 16'hFFFF; short_code = 2'd3;
    @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0 || ea !== e0 || sfr_sel !== s0 || fault !== f0 || short_val !== i0) begin
      fails++;
      $display("FAIL R10 idle: got v=%b ea=%h flt=%b, expected v=0 ea=%h flt=%b",
               out_valid, ea, fault, e0, f0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog expired: got no completion, expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R11: reset state
    vectors++;
    if (out_valid !== 0 || ea !== 0 || sfr_sel !== 0 || fault !== 0 || short_val !== 0) begin
      fails++;
      $display("FAIL R11 reset: got v=%b ea=%h sfr=%b flt=%b imm=%0d, expected all 0",
               out_valid, ea, sfr_sel, fault, short_val);
    end
    rst = 1'b0;

    // R1/R2: every 8-bit direct value, junk in upper field bits
    for (int i = 0; i < 256; i++) apply(3'd0, 16'(i) | 16'hA500, 16'h1234, 32'hFF00_0000, 16'h8000, 2'd3);
    idle_check();
    // R3: 16-bit direct stride sweep plus top value
    for (int i = 0; i < 65536; i += 257) apply(3'd1, 16'(i), 0, 32'hFFFF_FFFF, 0, 2'd3);
    apply(3'd1, 16'hFFFF, 0, 0, 0, 0);
    // R9: all alias slots with junk upper bits
    for (int i = 0; i < 64; i++) apply(3'd7, 16'(i) | 16'hFFC0, 16'hFFFF, 32'hFFFF_FFFF, 0, 2'd3);
    // R8: every short code
    for (int i = 0; i < 4; i++) apply(3'd6, 16'h00FF, 0, 32'hFF00_0000, 0, 2'(i));
    idle_check();
    // R6/R7 wrap corners
    apply(3'd4, 0, 16'hFFFF, 0, 16'h0001, 0);
    apply(3'd4, 0, 16'h0000, 0, 16'hFFFF, 0);
    apply(3'd5, 0, 0, 32'h00FF_FFFF, 16'h0001, 0);
    apply(3'd5, 0, 0, 32'h0000_0000, 16'hFFFF, 0);
    apply(3'd5, 0, 0, 32'h0001_0000, 16'h8000, 0);
    apply(3'd5, 0, 0, 32'h8012_0000, 16'h7FFF, 0);
    apply(3'd3, 0, 0, 32'h0100_0000, 0, 0);
    apply(3'd3, 0, 0, 32'h00AB_CDEF, 0, 0);
    // R4..R7: pseudo-random operands across register modes
    r = 32'h1D87_2A35;
    for (int i = 0; i < 400; i++) begin
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      apply(3'(2 + (i % 4)), r[15:0], r[31:16], (i % 3 == 0) ? {8'h00, r[23:0]} : r,
            r[20:5], r[1:0]);
      if (i % 50 == 0) idle_check();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule